// File: doc/BRIEF.md
# Pipelined Carry-Select Final Adder

This block is the carry-propagate stage at the end of a carry-save datapath. It takes the redundant pair that a compressor tree leaves behind, a sum vector and a carry vector, and reduces them to one binary word. The width is cut into 4-bit ripple segments. Every segment precomputes its result twice, once for an incoming carry of 0 and once for 1. The real block carry then walks up the segments and picks one result per segment through a multiplexer.

The work is spread over three register stages. The first registers the precomputed segment pairs. The second resolves the lower half of the segments. The third resolves the upper half and registers the result. A new operand pair can enter every cycle. The result is kept modulo 2^WIDTH, and the carry out of the top segment is dropped. A valid flag travels alongside the data, and a synchronous reset clears it.

Top module: `csel_final_adder`

## Requirements
- R1: When `in_valid` is high, `out_sum` equals `(in_sum_vec + in_carry_vec) mod 2^24` exactly 3 clock edges later.
- R2: `out_valid` equals `in_valid` delayed by exactly 3 clock edges. Inputs presented with `in_valid` low never produce a high `out_valid`.
- R3: A synchronous reset high at a clock edge clears all valid flags, so `out_valid` is low after that edge and stays low until a new valid operand has passed all 3 stages.
- R4: The carry out of bit 23 is discarded: 0xFFFFFF + 0x000001 gives 0x000000, and 0xFFFFFF + 0xFFFFFF gives 0xFFFFFE.
- R5: A carry produced in a low segment reaches every higher segment, across 4-bit boundaries and across the lower/upper half boundary between bits 11 and 12 (0x000FFF + 1 = 0x001000, 0x7FFFFF + 1 = 0x800000).
- R6: The adder accepts a new operand pair on every clock, and back-to-back results are independent of one another.
- R7: Operands that generate no carry (alternating 0xAAAAAA + 0x555555) give the bitwise OR, 0xFFFFFF. Operands that carry from every bit pair (0x555555 + 0x555555) give 0xAAAAAA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Operand pair is valid this cycle |
| in_sum_vec | input | 24 | Sum vector from the carry-save stage |
| in_carry_vec | input | 24 | Carry vector from the carry-save stage |
| out_valid | output | 1 | `out_sum` holds a result |
| out_sum | output | 24 | Binary sum modulo 2^24 |

## Verification
The bench aims at the carry chain, because a carry-select adder that fails usually fails at a segment boundary. A wrong select polarity or a stale block carry shows up as a result off by 16, 256 or 4096 when all-ones operands ripple through. A broken half boundary shows up as an error of exactly 4096 in results that cross from the registered lower half into the upper half. Overflowing operands catch an adder that leaks the top carry. Runs of alternating and random back-to-back operands with valid bubbles catch a misaligned delay register, which would pair a lower half with the wrong upper half or put the valid flag one cycle early or late. A mid-stream reset catches valid flags that survive the reset.

// File: rtl/csel_final_adder.sv
module csel_final_adder #(
  parameter int WIDTH = 24,
  parameter int SEG   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_sum_vec,
  input  logic [WIDTH-1:0] in_carry_vec,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum
);
  localparam int NSEG   = WIDTH / SEG;
  localparam int LOW    = NSEG / 2;
  localparam int HIGH   = NSEG - LOW;
  localparam int LOW_W  = LOW * SEG;
  localparam int HIGH_W = HIGH * SEG;
  localparam logic [SEG:0] ONE = {{SEG{1'b0}}, 1'b1};

  logic [2:0] v_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[1:0], in_valid};
  end
  assign out_valid = v_q[2];

  // stage 1: both carry-in outcomes for every segment
  logic [NSEG-1:0][SEG:0] pre0_d, pre1_d, pre0_q, pre1_q;

  for (genvar i = 0; i < NSEG; i++) begin : g_pre
    assign pre0_d[i] = {1'b0, in_sum_vec[i*SEG +: SEG]} + {1'b0, in_carry_vec[i*SEG +: SEG]};
    assign pre1_d[i] = pre0_d[i] + ONE;
  end

  always_ff @(posedge clk) begin
    pre0_q <= pre0_d;
    pre1_q <= pre1_d;
  end

  // stage 2: resolve the lower half, delay the upper pairs
  logic [LOW:0]      c_lo;
  logic [LOW_W-1:0]  lo_sum_d, lo_sum_q;
  logic              cmid_q;
  logic [HIGH-1:0][SEG:0] hi0_q, hi1_q;

  assign c_lo[0] = 1'b0;
  for (genvar j = 0; j < LOW; j++) begin : g_lo
    logic [SEG:0] pick;
    assign pick = c_lo[j] ? pre1_q[j] : pre0_q[j];
    assign lo_sum_d[j*SEG +: SEG] = pick[SEG-1:0];
    assign c_lo[j+1] = pick[SEG];
  end

  always_ff @(posedge clk) begin
    lo_sum_q <= lo_sum_d;
    cmid_q   <= c_lo[LOW];
    hi0_q    <= pre0_q[NSEG-1:LOW];
    hi1_q    <= pre1_q[NSEG-1:LOW];
  end

  // stage 3: resolve the upper half
  logic [HIGH:0]     c_hi;
  logic [HIGH_W-1:0] hi_sum_d;

  assign c_hi[0] = cmid_q;
  for (genvar k = 0; k < HIGH; k++) begin : g_hi
    logic [SEG:0] pick;
    assign pick = c_hi[k] ? hi1_q[k] : hi0_q[k];
    assign hi_sum_d[k*SEG +: SEG] = pick[SEG-1:0];
    assign c_hi[k+1] = pick[SEG];
  end

  always_ff @(posedge clk) out_sum <= {hi_sum_d, lo_sum_q};

  a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sum == $past(in_sum_vec, 3) + $past(in_carry_vec, 3));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  a_r3_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r5_lower_half: assert property (@(posedge clk) disable iff (rst)
    v_q[0] |-> {c_lo[LOW], lo_sum_d} ==
      {1'b0, $past(in_sum_vec[LOW_W-1:0])} + {1'b0, $past(in_carry_vec[LOW_W-1:0])});

  a_r4_full_carry: assert property (@(posedge clk) disable iff (rst)
    v_q[1] |-> {c_hi[HIGH], hi_sum_d, lo_sum_q} ==
      {1'b0, $past(in_sum_vec, 2)} + {1'b0, $past(in_carry_vec, 2)});
endmodule

// File: tb/tb_csel_final_adder.sv
module tb_csel_final_adder;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_sum;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  string cur_tag = "R6";
  logic [2:0]   mv;
  logic [W-1:0] ms [3];
  string        mt [3];

  always #2 clk = ~clk;

  csel_final_adder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_sum_vec(in_a), .in_carry_vec(in_b),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  // behavioural model: three-deep delay of the true sum
  always @(posedge clk) begin
    logic [W-1:0] s;
    s = in_a + in_b;
    if (rst) mv <= '0;
    else begin
      mv <= {mv[1:0], in_valid};
      ms[2] <= ms[1]; ms[1] <= ms[0]; ms[0] <= s;
      mt[2] <= mt[1]; mt[1] <= mt[0]; mt[0] <= cur_tag;
    end
  end

  always @(negedge clk) begin
    if (mv !== 3'bxxx) begin
      tests++;
      if (out_valid !== mv[2]) begin
        fails++;
        $display("FAIL R2: out_valid=%b expected %b", out_valid, mv[2]);
      end
      if (mv[2] === 1'b1) begin
        tests++;
        if (out_sum !== ms[2]) begin
          fails++;
          $display("FAIL %s/R1: out_sum=%h expected %h", mt[2], out_sum, ms[2]);
        end
      end
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; cur_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R3: out_valid=%b expected 0 after reset", out_valid);
    end
    drive(1, 24'hFFFFFF, 24'h000001, "R4");
    drive(1, 24'hFFFFFF, 24'hFFFFFF, "R4");
    drive(1, 24'h000FFF, 24'h000001, "R5");
    drive(1, 24'h7FFFFF, 24'h000001, "R5");
    drive(1, 24'h00000F, 24'h000001, "R5");
    drive(1, 24'h0FFFFF, 24'h000001, "R5");
    drive(1, 24'hAAAAAA, 24'h555555, "R7");
    drive(1, 24'h555555, 24'h555555, "R7");
    drive(1, 24'h000000, 24'h000000, "R1");
    for (int i = 0; i < 300; i++)
      drive(1, W'($urandom), W'($urandom), "R6");
    for (int i = 0; i < 300; i++)
      drive(1'($urandom), W'($urandom), W'($urandom), "R2");
    for (int i = 0; i < 5; i++)
      drive(1, W'($urandom), W'($urandom), "R3");
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R3: out_valid=%b expected 0 mid-stream", out_valid);
    end
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tests++;
      if (out_valid !== 1'b0) begin
        fails++; $display("FAIL R3: out_valid=%b expected 0 while refilling", out_valid);
      end
    end
    drive(1, 24'hFFF000, 24'h001000, "R4");
    drive(0, '0, '0, "R2");
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule